// File: doc/BRIEF.md
# Four-Lane Sign-Code Maximum Pooler

This block returns the largest of a set of signed samples and the position of that sample. Each step works on a group of four lanes. The block registers the group and forms all six pairwise differences with one guard bit. It keeps only the sign of each difference, in a 6-bit winner code, and decodes that code into the winning lane. It never builds a tree of comparators and multiplexers.

A set larger than four is reduced over several steps. The first group carries four samples. Each later group carries three new samples in lanes 1 to 3. Lane 0 of a later group is replaced inside the block by the winner so far. Lanes past the end of the set are padded with the most negative value. A rectifier option, chosen with the first group, clamps a negative final result to zero. Mean pooling is not offered.

Top module: `mpool_max4`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_value` and `out_index` are all zero.
- R2: A count from 1 to 4 gives one step over lanes 0 to count-1, with lane i at bits [i*W +: W] of `in_vals`. Lanes at or above the count have no effect on the result. A count of 0 is treated as 1.
- R3: When values are equal, the sample with the lowest position in the set wins. This holds between lanes and across steps.
- R4: Differences carry one guard bit, so the largest positive and most negative values are ordered correctly.
- R5: In a single-step reduction, `out_valid` goes high for exactly one cycle, three clock edges after the edge that captures the group.
- R6: A count above 4 takes 1 + ceil((count-4)/3) groups. The first group holds positions 0 to 3. Each later group holds the next three positions in lanes 1 to 3. Lane 0, `in_count` and `in_relu` of later groups are ignored. `out_index` is the winner's position in the whole set.
- R7: Lanes of the last group beyond the remaining count have no effect on the result.
- R8: `in_relu` is sampled with the first group. When it is set, a negative result is output as zero with its index unchanged. A non-negative result passes through unchanged.
- R9: `in_valid` is ignored on the two clock edges that follow an accepted group. The next group is accepted from the third edge on.
- R10: Each reduction produces exactly one `out_valid` pulse, and only after its last group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A group of four lanes is offered |
| in_vals | input | 4*W | Four signed lanes, lane i at [i*W +: W] |
| in_count | input | CW | Number of samples in the set, read with the first group |
| in_relu | input | 1 | Clamp a negative result to zero, read with the first group |
| out_valid | output | 1 | One-cycle pulse when the result is ready |
| out_value | output | W | Maximum sample, after the optional clamp |
| out_index | output | CW | Position of the maximum in the set |

## Verification
The hardest case is a multi-step reduction in which the stored winner must beat or tie later samples. This depends on the fed-back lane 0 and the padding of the last group. No port shows either of these directly. The stimulus drives a large decoy value into every ignored lane: lane 0 of later groups and the lanes past the count. It also flips `in_relu` and `in_count` on later groups. As a result, any leak of an ignored input changes the reported maximum or index. Tie runs put equal values in the first group and in the last group, so the position rule is checked across steps.

// File: rtl/mpool_pkg.sv
package mpool_pkg;
  localparam int LANES = 4;
  localparam int PAIRS = LANES * (LANES - 1) / 2;

  // lower lane of pair k, pairs enumerated (0,1)(0,2)(0,3)(1,2)(1,3)(2,3)
  function automatic int pair_lo(input int k);
    if (k < 3) return 0;
    else if (k < 5) return 1;
    else return 2;
  endfunction

  function automatic int pair_hi(input int k);
    if (k < 3) return k + 1;
    else if (k < 5) return k - 1;
    else return 3;
  endfunction
endpackage

// File: rtl/mpool_sign_code.sv
module mpool_sign_code
  import mpool_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [LANES*W-1:0]   vals,
  output logic [PAIRS-1:0]     code
);
  localparam int DW = W + 1;
  logic [PAIRS-1:0] code_d;

  // bit k set means the higher lane of pair k is strictly larger
  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    localparam int LO = pair_lo(k);
    localparam int HI = pair_hi(k);
    logic signed [DW-1:0] a_ext, b_ext, diff;
    assign a_ext  = $signed({vals[LO*W+W-1], vals[LO*W +: W]});
    assign b_ext  = $signed({vals[HI*W+W-1], vals[HI*W +: W]});
    assign diff   = a_ext - b_ext;
    assign code_d[k] = diff[DW-1];
  end

  always_ff @(posedge clk) begin
    if (rst) code <= '0;
    else if (en) code <= code_d;
  end
endmodule

// File: rtl/mpool_code_decode.sv
module mpool_code_decode
  import mpool_pkg::*;
(
  input  logic [PAIRS-1:0] code,
  output logic [LANES-1:0] onehot,
  output logic [1:0]       lane
);
  always_comb begin
    onehot[0] = ~code[0] & ~code[1] & ~code[2];
    onehot[1] =  code[0] & ~code[3] & ~code[4];
    onehot[2] =  code[1] &  code[3] & ~code[5];
    onehot[3] =  code[2] &  code[4] &  code[5];
    lane = 2'd0;
    for (int i = LANES - 1; i > 0; i--)
      if (onehot[i]) lane = 2'(i);
  end
endmodule

// File: rtl/mpool_max4.sv
module mpool_max4
  import mpool_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [LANES*W-1:0]  in_vals,
  input  logic [CW-1:0]       in_count,
  input  logic                in_relu,
  output logic                out_valid,
  output logic [W-1:0]        out_value,
  output logic [CW-1:0]       out_index
);
  localparam logic [W-1:0] VMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [CW-1:0] FIRST_N = CW'(LANES);
  localparam logic [CW-1:0] LATER_N = CW'(LANES - 1);

  // sequencing state
  logic          busy, run, relu_q;
  logic [CW-1:0] rem, base;
  // capture stage
  logic                 cap_v, cap_last;
  logic [LANES*W-1:0]   cap_vals;
  logic [LANES*CW-1:0]  cap_idx;
  // code stage
  logic                 s1_v, s1_last;
  logic [LANES*W-1:0]   s1_vals;
  logic [LANES*CW-1:0]  s1_idx;
  logic [PAIRS-1:0]     code;
  logic [LANES-1:0]     win_onehot;
  logic [1:0]           win_lane;
  // decode stage
  logic                 dec_v, dec_last;
  logic [W-1:0]         win_val;
  logic [CW-1:0]        win_idx;

  logic                 accept, nxt_last;
  logic [CW-1:0]        cnt_eff;
  logic [LANES*W-1:0]   nxt_vals;
  logic [LANES*CW-1:0]  nxt_idx;

  assign accept = in_valid & ~busy;

  always_comb begin
    cnt_eff  = (in_count == '0) ? CW'(1) : in_count;
    nxt_last = run ? (rem <= LATER_N) : (cnt_eff <= FIRST_N);
    for (int i = 0; i < LANES; i++) begin
      if (!run) begin
        nxt_vals[i*W +: W]   = (CW'(i) < cnt_eff) ? in_vals[i*W +: W] : VMIN;
        nxt_idx[i*CW +: CW]  = CW'(i);
      end else if (i == 0) begin
        nxt_vals[i*W +: W]   = win_val;
        nxt_idx[i*CW +: CW]  = win_idx;
      end else begin
        nxt_vals[i*W +: W]   = (CW'(i - 1) < rem) ? in_vals[i*W +: W] : VMIN;
        nxt_idx[i*CW +: CW]  = base + CW'(i - 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; run <= 1'b0; relu_q <= 1'b0;
      rem <= '0; base <= '0;
      cap_v <= 1'b0; cap_last <= 1'b0; cap_vals <= '0; cap_idx <= '0;
    end else begin
      cap_v <= accept;
      if (accept) begin
        busy     <= 1'b1;
        cap_vals <= nxt_vals;
        cap_idx  <= nxt_idx;
        cap_last <= nxt_last;
        if (!run) begin
          relu_q <= in_relu;
          if (!nxt_last) begin
            run  <= 1'b1;
            rem  <= cnt_eff - FIRST_N;
            base <= FIRST_N;
          end
        end else if (nxt_last) begin
          run <= 1'b0;
        end else begin
          rem  <= rem - LATER_N;
          base <= base + LATER_N;
        end
      end else if (s1_v) begin
        busy <= 1'b0;
      end
    end
  end

  mpool_sign_code #(.W(W)) u_code (
    .clk (clk), .rst (rst), .en (cap_v), .vals (cap_vals), .code (code)
  );

  mpool_code_decode u_dec (
    .code (code), .onehot (win_onehot), .lane (win_lane)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_last <= 1'b0; s1_vals <= '0; s1_idx <= '0;
      dec_v <= 1'b0; dec_last <= 1'b0; win_val <= '0; win_idx <= '0;
      out_valid <= 1'b0; out_value <= '0; out_index <= '0;
    end else begin
      s1_v <= cap_v;
      if (cap_v) begin
        s1_vals <= cap_vals;
        s1_idx  <= cap_idx;
        s1_last <= cap_last;
      end
      dec_v <= s1_v;
      if (s1_v) begin
        win_val  <= s1_vals[win_lane*W +: W];
        win_idx  <= s1_idx[win_lane*CW +: CW];
        dec_last <= s1_last;
      end
      out_valid <= dec_v & dec_last;
      if (dec_v && dec_last) begin
        out_value <= (relu_q && win_val[W-1]) ? '0 : win_val;
        out_index <= win_idx;
      end
    end
  end
endmodule

// File: rtl/mpool_max4_chk.sv
module mpool_max4_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         busy,
  input logic [4*W-1:0] cap_vals,
  input logic         s1_v,
  input logic [3:0]   win_onehot,
  input logic         out_valid,
  input logic [W-1:0] out_value,
  input logic         relu_q
);
  // R3
  single_winner_chk: assert property (@(posedge clk) disable iff (rst)
    s1_v |-> $countones(win_onehot) == 1);

  // R5
  one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8
  relu_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_value[W-1] && $past(relu_q)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cap_vals));
endmodule

bind mpool_max4 mpool_max4_chk #(.W(W)) u_chk (
  .clk (clk), .rst (rst), .busy (busy), .cap_vals (cap_vals),
  .s1_v (s1_v), .win_onehot (win_onehot), .out_valid (out_valid),
  .out_value (out_value), .relu_q (relu_q)
);

// File: tb/mpool_max4_test.sv
module mpool_max4_test;
  localparam int W = 8;
  localparam int CW = 8;
  localparam logic [7:0] DECOY = 8'h7F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [4*W-1:0] in_vals = '0;
  logic [CW-1:0] in_count = '0;
  logic in_relu = 1'b0;
  logic out_valid;
  logic [W-1:0] out_value;
  logic [CW-1:0] out_index;

  int checks = 0;
  int fails = 0;
  logic signed [7:0] vbuf [16];

  always #10 clk = ~clk;

  mpool_max4 #(.W(W), .CW(CW)) uut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_vals (in_vals),
    .in_count (in_count), .in_relu (in_relu), .out_valid (out_valid),
    .out_value (out_value), .out_index (out_index)
  );

  // single-group vectors: {count, relu, lane0, lane1, lane2, lane3}
  localparam int NTV = 12;
  localparam logic [40:0] TV [NTV] = '{
    {8'd4, 1'b0, 8'h03, 8'h09, 8'hFE, 8'h05},
    {8'd4, 1'b0, 8'hFF, 8'hF9, 8'hFD, 8'hFE},
    {8'd4, 1'b0, 8'h04, 8'h04, 8'h08, 8'h08},
    {8'd4, 1'b0, 8'h80, 8'h7F, 8'h00, 8'h01},
    {8'd4, 1'b0, 8'h7F, 8'h80, 8'h80, 8'h80},
    {8'd2, 1'b0, 8'h01, 8'h02, 8'h64, 8'h78},
    {8'd0, 1'b0, 8'hFB, 8'h0A, 8'h14, 8'h1E},
    {8'd4, 1'b1, 8'hF7, 8'hFD, 8'hFC, 8'h9C},
    {8'd4, 1'b1, 8'h06, 8'hFD, 8'h02, 8'h07},
    {8'd3, 1'b0, 8'h80, 8'h80, 8'h80, 8'h7F},
    {8'd1, 1'b1, 8'h80, 8'h10, 8'h20, 8'h30},
    {8'd4, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ref_max(input int n, input bit relu, output int val, output int idx);
    int neff = (n < 1) ? 1 : n;
    val = vbuf[0]; idx = 0;
    for (int i = 1; i < neff; i++)
      if (vbuf[i] > val) begin val = vbuf[i]; idx = i; end
    if (relu && val < 0) val = 0;
  endtask

  task automatic send(input logic [4*W-1:0] v, input int cnt, input bit relu);
    @(negedge clk);
    in_valid = 1'b1; in_vals = v; in_count = CW'(cnt); in_relu = relu;
    @(negedge clk);
    in_valid = 1'b0; in_vals = '0;
  endtask

  task automatic collect(input string req, input int ev, input int ei, input int elat);
    int pulses = 0;
    int first = -1;
    int gv = 0;
    int gi = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (out_valid) begin
        pulses++;
        if (first < 0) begin
          first = k; gv = $signed(out_value); gi = int'(out_index);
        end
      end
    end
    chk(gv == ev, {req, " value"}, gv, ev);
    chk(gi == ei, {req, " index"}, gi, ei);
    chk(pulses == 1, "R10 pulse count", pulses, 1);
    if (elat > 0) chk(first == elat, "R5 latency", first, elat);
  endtask

  // run a reduction over vbuf[0..n-1]; ignored lanes carry decoys
  task automatic run_op(input int n, input bit relu, input string req);
    int neff = (n < 1) ? 1 : n;
    int pos = 0;
    int ev, ei;
    logic [4*W-1:0] v;
    for (int i = 0; i < 4; i++)
      v[i*W +: W] = (i < neff) ? vbuf[i] : DECOY;
    send(v, n, relu);
    pos = 4;
    while (pos < neff) begin
      v[0 +: W] = DECOY;
      for (int j = 1; j < 4; j++)
        v[j*W +: W] = (pos + j - 1 < neff) ? vbuf[pos + j - 1] : DECOY;
      @(negedge clk);
      send(v, 0, !relu);
      pos += 3;
    end
    ref_max(n, relu, ev, ei);
    collect(req, ev, ei, 3);
  endtask

  initial begin
    #3000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(out_value == '0, "R1 out_value", int'(out_value), 0);
    chk(out_index == '0, "R1 out_index", int'(out_index), 0);
    rst = 1'b0;

    // R2 R3 R4 R8 single-group table
    for (int t = 0; t < NTV; t++) begin
      vbuf[0] = TV[t][31:24]; vbuf[1] = TV[t][23:16];
      vbuf[2] = TV[t][15:8];  vbuf[3] = TV[t][7:0];
      run_op(int'(TV[t][40:33]), TV[t][32], "R2 R3 R4 R8 table");
    end

    // R6 exact two groups
    for (int i = 0; i < 16; i++) vbuf[i] = 8'(i * 7 - 50);
    vbuf[5] = 8'sd90;
    run_op(7, 1'b0, "R6 two groups");

    // R7 padding in the last group, winner in a pad-adjacent lane
    for (int i = 0; i < 16; i++) vbuf[i] = -8'sd20;
    vbuf[8] = 8'sd3;
    run_op(9, 1'b0, "R7 padded last group");

    // R6 five samples, winner carried from first group
    for (int i = 0; i < 16; i++) vbuf[i] = 8'(i);
    vbuf[2] = 8'sd100;
    run_op(5, 1'b0, "R6 carried winner");

    // R3 tie across steps: first group holds the earliest copy
    for (int i = 0; i < 16; i++) vbuf[i] = -8'sd1;
    vbuf[1] = 8'sd44; vbuf[11] = 8'sd44;
    run_op(13, 1'b0, "R3 tie across groups");

    // R8 all negative over four groups with clamp
    for (int i = 0; i < 16; i++) vbuf[i] = 8'(-100 + i);
    run_op(13, 1'b1, "R8 clamp multi");

    // R4 extremes over 16 samples
    for (int i = 0; i < 16; i++) vbuf[i] = -8'sd128;
    vbuf[15] = 8'sd127;
    run_op(16, 1'b0, "R4 extremes multi");

    // R9 in_valid held across busy edges
    @(negedge clk);
    in_valid = 1'b1; in_count = 8'd4; in_relu = 1'b0;
    in_vals = {8'h02, 8'h11, 8'h05, 8'hF0};
    @(negedge clk);
    in_vals = {8'h7F, 8'h7F, 8'h7F, 8'h7F};
    @(negedge clk);
    in_vals = {8'h60, 8'h60, 8'h60, 8'h60};
    @(negedge clk);
    in_valid = 1'b0; in_vals = '0;
    collect("R9 busy ignore", 17, 2, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule